// File: doc/BRIEF.md
# Ping-pong DMA channel

This block is one DMA channel that copies data element by element, either from a peripheral into memory or from one memory region to another. It holds two buffer descriptors, A and B. Each has its own source address, destination address and remaining element count. Software arms a buffer by writing a non-zero count. The channel then serves the armed buffers in alternating order, so that one buffer can be refilled while the other drains.

Each element is a single read request at the source address, followed by a single write request that carries the read data to the destination address. Both requests go out on a simple request/acknowledge memory master port. The channel can be paused. It can insert a programmed number of idle clocks after every element. In paced mode it waits for a peripheral-ready input before each element. A per-buffer completion flag drives an interrupt output that software can mask.

Top module: `pp_dma_channel`

## Requirements
- R1: Register offsets on `cfg_addr` are: 0 control, 1 status, 2/3/4 buffer A source/destination/count, 5/6/7 buffer B source/destination/count. Reads are combinational. After reset, status, counts and addresses read 0, `irq` is 0 and `mem_req` is 0.
- R2: Writing a non-zero value to a count register arms that buffer, and a transfer starts if the channel is free and not paused. Writing zero starts nothing.
- R3: An element is a read at the current source address, then a write of the returned data to the current destination address. `mem_size` equals control bits 3:2. A request is held with stable direction until `mem_ack`.
- R4: Control bits 11:10 set source increment and bits 13:12 set destination increment. 00 keeps the address fixed. Any other value advances it after each element by 1, 2 or 4 for size 00, 01 or 10 (11 behaves as 10).
- R5: Each element decrements the active count. When it reaches zero, status bit 0 (A) or bit 1 (B) is set, and the count register reads the remaining elements.
- R6: Writing control with bit 7 set clears the A flag, and with bit 8 set clears the B flag. A completion in the same cycle wins.
- R7: `irq` is high exactly when control bit 6 is set and at least one completion flag is set.
- R8: At each decision point the preferred buffer is served if armed, otherwise the other one. The preference is A after reset or a channel reset, and it flips to the other buffer when a buffer completes. A buffer switch adds no idle cycle beyond the wait states.
- R9: While control bit 4 (pause) is set, no new element begins. An element already issued finishes first, and count writes made during pause wait for its release.
- R10: After each write acknowledge, exactly control[21:14] clocks pass with `mem_req` low before the next element is decided.
- R11: When control bit 0 is 1, each element's read request is issued only after `periph_rdy` has been seen high.
- R12: Writing control with bit 5 set aborts any element, clears both counts, both addresses of each buffer and both flags, and returns the preference to A.
- R13: `periph_sel` reflects control[26:23], `chan_dir` reflects bit 1 and `chan_hi_pri` reflects bit 9. The control register reads back with bits 5, 7 and 8 as 0, because those bits are strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request accepted |
| periph_rdy | input | 1 | Peripheral ready for pacing |
| periph_sel | output | 4 | Selected peripheral |
| chan_dir | output | 1 | Direction bit |
| chan_hi_pri | output | 1 | Priority bit toward an arbiter |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is the decision that coincides with the last write acknowledge of a buffer. At that moment the outgoing count is still one and the other buffer is already armed. To create it, the bench arms both buffers while pause is held and then releases pause. The scoreboard then checks the service order, and the bench counts the idle cycles between the final write of one buffer and the first read of the other. A second hard case is pausing or resetting the channel in the middle of a buffer. The bench times those control writes off the write-acknowledge count it observes, so that they fall inside an element or a wait gap.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

   localparam logic [2:0] OFS_CTRL  = 3'd0;
   localparam logic [2:0] OFS_STAT  = 3'd1;
   localparam logic [2:0] OFS_A_SRC = 3'd2;
   localparam logic [2:0] OFS_A_DST = 3'd3;
   localparam logic [2:0] OFS_A_CNT = 3'd4;
   localparam logic [2:0] OFS_B_SRC = 3'd5;
   localparam logic [2:0] OFS_B_DST = 3'd6;
   localparam logic [2:0] OFS_B_CNT = 3'd7;

   localparam int BIT_CHAN_RST = 5;
   localparam int BIT_CLR_A    = 7;
   localparam int BIT_CLR_B    = 8;
   // bits kept in the control register; strobes and unused bits read 0
   localparam logic [31:0] CTRL_KEEP = 32'h07BF_FE5F;

   typedef enum logic [2:0] {
      ENG_IDLE, ENG_RDY, ENG_RD, ENG_WR, ENG_GAP
   } eng_state_e;

   typedef struct packed {
      logic [3:0] periph_sel;
      logic [7:0] wait_n;
      logic [1:0] dst_inc;
      logic [1:0] src_inc;
      logic       hi_pri;
      logic       irq_en;
      logic       pause;
      logic [1:0] size;
      logic       dir;
      logic       paced;
   } ctrl_t;

   function automatic ctrl_t decode_ctrl(input logic [31:0] w);
      ctrl_t c;
      c.periph_sel = w[26:23];
      c.wait_n     = w[21:14];
      c.dst_inc    = w[13:12];
      c.src_inc    = w[11:10];
      c.hi_pri     = w[9];
      c.irq_en     = w[6];
      c.pause      = w[4];
      c.size       = w[3:2];
      c.dir        = w[1];
      c.paced      = w[0];
      return c;
   endfunction

   function automatic logic [2:0] size_step(input logic [1:0] sz);
      case (sz)
         2'b00:   return 3'd1;
         2'b01:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we_src,
   input  logic              we_dst,
   input  logic              we_cnt,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              adv,
   input  logic [2:0]        src_step,
   input  logic [2:0]        dst_step,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [CNT_W-1:0]  cnt,
   output logic              done
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("pp_dma_desc: ADDR_W must lie in 8..32");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("pp_dma_desc: CNT_W must lie in 2..32");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   assign done = adv && !we_cnt && !clr && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
      end else if (clr) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
      end else begin
         if (we_src)   src <= addr_wdata;
         else if (adv) src <= src + ADDR_W'(src_step);
         if (we_dst)   dst <= addr_wdata;
         else if (adv) dst <= dst + ADDR_W'(dst_step);
         if (we_cnt)                  cnt <= cnt_wdata;
         else if (adv && cnt != '0)   cnt <= cnt - CNT_ONE;
      end
   end

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !we_cnt && !clr && cnt != '0) |=> (cnt == $past(cnt) - CNT_ONE));

endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
   import pp_dma_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl,
   input  logic [31:0] wdata,
   input  logic [1:0]  done,
   output ctrl_t       cfg,
   output logic [31:0] ctrl_word,
   output logic [1:0]  flags,
   output logic        clr,
   output logic        irq
);

   logic [1:0] clr_flag;
   logic       irq_c;

   assign clr         = wr_ctrl && wdata[BIT_CHAN_RST];
   assign clr_flag[0] = wr_ctrl && wdata[BIT_CLR_A];
   assign clr_flag[1] = wr_ctrl && wdata[BIT_CLR_B];
   assign cfg         = decode_ctrl(ctrl_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_word <= '0;
         flags     <= '0;
      end else begin
         if (wr_ctrl) ctrl_word <= wdata & CTRL_KEEP;
         if (clr) flags <= '0;
         else     flags <= (flags & ~clr_flag) | done;
      end
   end

   assign irq_c = cfg.irq_en && (flags != 2'b00);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[BIT_CLR_A] && !done[0]) |=> !flags[0]);

   assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done[1] && !clr) |=> flags[1]);

endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
   import pp_dma_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int WAIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              pause,
   input  logic              paced,
   input  logic [WAIT_W-1:0] wait_n,
   input  logic [CNT_W-1:0]  cnt_a,
   input  logic [CNT_W-1:0]  cnt_b,
   input  logic              periph_rdy,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              cur,
   output logic              adv
);

   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

   eng_state_e        state;
   logic              pref;
   logic [WAIT_W-1:0] gap_q;
   logic [DATA_W-1:0] data_q;
   logic              wr_done, last_a, last_b, at_point, go, pick;
   logic [1:0]        arm;

   always_comb begin
      wr_done  = (state == ENG_WR) && mem_ack;
      last_a   = wr_done && !cur && (cnt_a == CNT_ONE);
      last_b   = wr_done &&  cur && (cnt_b == CNT_ONE);
      arm[0]   = (cnt_a != '0) && !last_a;
      arm[1]   = (cnt_b != '0) && !last_b;
      at_point = (state == ENG_IDLE) || (wr_done && wait_n == '0) ||
                 ((state == ENG_GAP) && gap_q == WAIT_ONE);
      go       = at_point && !pause && (arm != 2'b00);
      pick     = arm[pref] ? pref : !pref;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ENG_IDLE;
         pref   <= 1'b0;
         cur    <= 1'b0;
         gap_q  <= '0;
         data_q <= '0;
      end else if (clr) begin
         state <= ENG_IDLE;
         pref  <= 1'b0;
      end else begin
         if (go) begin
            cur   <= pick;
            pref  <= pick;
            state <= paced ? ENG_RDY : ENG_RD;
         end else if (at_point) begin
            state <= ENG_IDLE;
         end else begin
            case (state)
               ENG_RDY: if (periph_rdy && !pause) state <= ENG_RD;
               ENG_RD:  if (mem_ack) begin
                           data_q <= mem_rdata;
                           state  <= ENG_WR;
                        end
               ENG_WR:  if (mem_ack) begin
                           gap_q <= wait_n;
                           state <= ENG_GAP;
                        end
               ENG_GAP: gap_q <= gap_q - WAIT_ONE;
               default: ;
            endcase
         end
         if ((last_a || last_b) && !go) pref <= !cur;
      end
   end

   assign mem_req   = (state == ENG_RD) || (state == ENG_WR);
   assign mem_we    = (state == ENG_WR);
   assign mem_wdata = data_q;
   assign adv       = wr_done;

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

   assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && !mem_req) |=> !mem_req);

   assert_wait_gap_R10: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (wr_done && wait_n != '0) |=> !mem_req);

   assert_paced_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && $past(paced)) |-> $past(periph_rdy));

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
   import pp_dma_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   input  logic              periph_rdy,
   output logic [3:0]        periph_sel,
   output logic              chan_dir,
   output logic              chan_hi_pri,
   output logic              irq
);

   if (DATA_W < 8) begin : g_bad_data
      $error("pp_dma_channel: DATA_W must be at least 8");
   end

   localparam int N_BUF  = 2;
   localparam int WAIT_W = 8;

   ctrl_t                        cfg;
   logic [31:0]                  ctrl_word;
   logic [1:0]                   flags, done;
   logic                         clr, cur, adv;
   logic [2:0]                   step, src_step, dst_step;
   logic [N_BUF-1:0][ADDR_W-1:0] src_q, dst_q;
   logic [N_BUF-1:0][CNT_W-1:0]  cnt_q;

   assign step     = size_step(cfg.size);
   assign src_step = (cfg.src_inc != 2'b00) ? step : 3'd0;
   assign dst_step = (cfg.dst_inc != 2'b00) ? step : 3'd0;

   pp_dma_ctrl #(.IRQ_REG(IRQ_REG)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (cfg_wr && cfg_addr == OFS_CTRL),
      .wdata     (cfg_wdata),
      .done      (done),
      .cfg       (cfg),
      .ctrl_word (ctrl_word),
      .flags     (flags),
      .clr       (clr),
      .irq       (irq)
   );

   for (genvar b = 0; b < N_BUF; b++) begin : g_buf
      localparam logic [2:0] BASE = OFS_A_SRC + 3'(3 * b);
      pp_dma_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (clr),
         .we_src     (cfg_wr && cfg_addr == BASE),
         .we_dst     (cfg_wr && cfg_addr == BASE + 3'd1),
         .we_cnt     (cfg_wr && cfg_addr == BASE + 3'd2),
         .addr_wdata (cfg_wdata[ADDR_W-1:0]),
         .cnt_wdata  (cfg_wdata[CNT_W-1:0]),
         .adv        (adv && (cur == 1'(b))),
         .src_step   (src_step),
         .dst_step   (dst_step),
         .src        (src_q[b]),
         .dst        (dst_q[b]),
         .cnt        (cnt_q[b]),
         .done       (done[b])
      );
   end

   pp_dma_engine #(.CNT_W(CNT_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .pause      (cfg.pause),
      .paced      (cfg.paced),
      .wait_n     (cfg.wait_n),
      .cnt_a      (cnt_q[0]),
      .cnt_b      (cnt_q[1]),
      .periph_rdy (periph_rdy),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .cur        (cur),
      .adv        (adv)
   );

   assign mem_addr    = mem_we ? dst_q[cur] : src_q[cur];
   assign mem_size    = cfg.size;
   assign periph_sel  = cfg.periph_sel;
   assign chan_dir    = cfg.dir;
   assign chan_hi_pri = cfg.hi_pri;

   always_comb begin
      case (cfg_addr)
         OFS_CTRL:  cfg_rdata = ctrl_word;
         OFS_STAT:  cfg_rdata = {30'b0, flags};
         OFS_A_SRC: cfg_rdata = 32'(src_q[0]);
         OFS_A_DST: cfg_rdata = 32'(dst_q[0]);
         OFS_A_CNT: cfg_rdata = 32'(cnt_q[0]);
         OFS_B_SRC: cfg_rdata = 32'(src_q[1]);
         OFS_B_DST: cfg_rdata = 32'(dst_q[1]);
         default:   cfg_rdata = 32'(cnt_q[1]);
      endcase
   end

   assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !IRQ_REG) |-> (flags != 2'b00));

endmodule

// File: tb/pp_dma_channel_bench.sv
module pp_dma_channel_bench;

   localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1;
   localparam logic [2:0] R_ASRC = 3'd2, R_ADST = 3'd3, R_ACNT = 3'd4;
   localparam logic [2:0] R_BSRC = 3'd5, R_BDST = 3'd6, R_BCNT = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;
   logic        periph_rdy = 1'b0;
   logic [3:0]  periph_sel;
   logic        chan_dir, chan_hi_pri, irq;

   always #4 clk = ~clk;

   pp_dma_channel u_pp_dma_channel (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .periph_rdy(periph_rdy), .periph_sel(periph_sel), .chan_dir(chan_dir),
      .chan_hi_pri(chan_hi_pri), .irq(irq)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
   endfunction

   // memory slave: acknowledge one cycle after a request, alternating
   always @(posedge clk or negedge rst_n)
      if (!rst_n) mem_ack <= 1'b0;
      else        mem_ack <= mem_req && !mem_ack;
   assign mem_rdata = pat(mem_addr);

   int n_chk = 0, n_fail = 0, wr_seen = 0, cyc = 0;
   logic [65:0] exp_q[$];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: compares each observed write with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ack) begin
         logic [65:0] it;
         wr_seen++;
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3 unexpected write: actual %h expected none", mem_addr);
         end else begin
            it = exp_q.pop_front();
            check("R3", "write address", mem_addr, it[65:34]);
            check("R3", "write data", mem_wdata, it[33:2]);
            check("R3", "write size", {30'b0, mem_size}, {30'b0, it[1:0]});
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   // driver side of the scoreboard
   task automatic expect_elems(input logic [31:0] src, input logic [31:0] dst,
                               input int n, input int ss, input int ds,
                               input logic [1:0] sz);
      for (int i = 0; i < n; i++)
         exp_q.push_back({dst + 32'(i * ds), pat(src + 32'(i * ss)), sz});
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic wait_flags(input logic [31:0] mask, input string req);
      logic [31:0] s;
      int t = 0;
      do begin
         rd(R_STAT, s);
         t++;
      end while ((s & mask) != mask && t < 3000);
      check(req, "completion flags", s & mask, mask);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic gap_after_write(output int gap);
      int t = 0;
      do @(negedge clk); while (!(mem_req && mem_we && mem_ack));
      gap = 0;
      @(negedge clk);
      while (!mem_req && t < 1000) begin
         gap++; t++;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input int psel, input int wt,
      input int dinc, input int sinc, input bit pri, input bit ie,
      input bit pause, input int sz, input bit dir, input bit paced);
      logic [31:0] w = '0;
      w[26:23] = 4'(psel); w[21:14] = 8'(wt); w[13:12] = 2'(dinc);
      w[11:10] = 2'(sinc); w[9] = pri; w[6] = ie; w[4] = pause;
      w[3:2] = 2'(sz); w[1] = dir; w[0] = paced;
      return w;
   endfunction

   initial begin
      logic [31:0] v, c;
      int g, base;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(R_STAT, v);  check("R1", "status after reset", v, 32'd0);
      rd(R_ACNT, v);  check("R1", "A count after reset", v, 32'd0);
      rd(R_BSRC, v);  check("R1", "B source after reset", v, 32'd0);
      check("R1", "irq after reset", {31'b0, irq}, 32'd0);
      check("R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);

      // R2 zero count does not start
      wr(R_CTRL, mk_ctrl(0, 0, 1, 1, 0, 1, 0, 2, 0, 0));
      wr(R_ACNT, 32'd0);
      idle(10);
      check("R2", "no request on zero count", {31'b0, mem_req}, 32'd0);

      // R2 R3 R4 R5 R7 word copy, both addresses increment
      wr(R_ASRC, 32'h100);
      wr(R_ADST, 32'h200);
      expect_elems(32'h100, 32'h200, 3, 4, 4, 2'd2);
      wr(R_ACNT, 32'd3);
      wait_flags(32'h1, "R5");
      rd(R_ACNT, v);  check("R5", "A count drained", v, 32'd0);
      rd(R_ASRC, v);  check("R4", "A source advanced by words", v, 32'h10C);
      rd(R_ADST, v);  check("R4", "A destination advanced", v, 32'h20C);
      check("R7", "irq with enable and flag", {31'b0, irq}, 32'd1);

      // R6 clear A flag
      wr(R_CTRL, mk_ctrl(0, 0, 1, 1, 0, 1, 0, 2, 0, 0) | 32'h80);
      rd(R_STAT, v);  check("R6", "A flag cleared", v, 32'd0);
      check("R7", "irq low after clear", {31'b0, irq}, 32'd0);

      // R12 R8 R9: reset preference, arm B then A under pause
      wr(R_CTRL, mk_ctrl(0, 0, 1, 0, 0, 0, 1, 1, 0, 0) | 32'h20);
      wr(R_BSRC, 32'h300); wr(R_BDST, 32'h400); wr(R_BCNT, 32'd2);
      wr(R_ASRC, 32'h500); wr(R_ADST, 32'h600); wr(R_ACNT, 32'd2);
      idle(20);
      check("R9", "no start while paused", {31'b0, mem_req}, 32'd0);
      expect_elems(32'h500, 32'h600, 2, 0, 2, 2'd1);
      expect_elems(32'h300, 32'h400, 2, 0, 2, 2'd1);
      wr(R_CTRL, mk_ctrl(0, 0, 1, 0, 0, 0, 0, 1, 0, 0));
      wait_flags(32'h3, "R8");
      check("R7", "irq masked when disabled", {31'b0, irq}, 32'd0);
      rd(R_BSRC, v);  check("R4", "fixed source stays", v, 32'h300);
      rd(R_BDST, v);  check("R4", "halfword destination step", v, 32'h404);

      // R10 five wait states
      wr(R_CTRL, mk_ctrl(0, 5, 1, 1, 0, 0, 0, 2, 0, 0) | 32'h180);
      wr(R_ASRC, 32'h700); wr(R_ADST, 32'h800);
      expect_elems(32'h700, 32'h800, 3, 4, 4, 2'd2);
      wr(R_ACNT, 32'd3);
      gap_after_write(g);
      check("R10", "idle cycles after write", 32'(g), 32'd5);
      wait_flags(32'h1, "R10");

      // R8 no idle at switch; A finished last so B goes first
      wr(R_CTRL, mk_ctrl(0, 0, 1, 1, 0, 0, 1, 0, 0, 0) | 32'h80);
      wr(R_ASRC, 32'h10); wr(R_ADST, 32'h20); wr(R_ACNT, 32'd1);
      wr(R_BSRC, 32'h30); wr(R_BDST, 32'h40); wr(R_BCNT, 32'd1);
      expect_elems(32'h30, 32'h40, 1, 1, 1, 2'd0);
      expect_elems(32'h10, 32'h20, 1, 1, 1, 2'd0);
      wr(R_CTRL, mk_ctrl(0, 0, 1, 1, 0, 0, 0, 0, 0, 0));
      gap_after_write(g);
      check("R8", "idle cycles at buffer switch", 32'(g), 32'd0);
      wait_flags(32'h3, "R8");

      // R11 paced mode waits for peripheral ready
      wr(R_CTRL, mk_ctrl(0, 0, 1, 1, 0, 0, 0, 2, 0, 1) | 32'h180);
      wr(R_ASRC, 32'hD00); wr(R_ADST, 32'hE00);
      expect_elems(32'hD00, 32'hE00, 2, 4, 4, 2'd2);
      wr(R_ACNT, 32'd2);
      idle(20);
      check("R11", "no request without ready", {31'b0, mem_req}, 32'd0);
      periph_rdy = 1'b1;
      wait_flags(32'h1, "R11");
      periph_rdy = 1'b0;

      // R9 pause in the middle of a buffer
      wr(R_CTRL, mk_ctrl(0, 3, 1, 1, 0, 0, 0, 2, 0, 0) | 32'h180);
      wr(R_ASRC, 32'h900); wr(R_ADST, 32'hA00);
      expect_elems(32'h900, 32'hA00, 6, 4, 4, 2'd2);
      base = wr_seen;
      wr(R_ACNT, 32'd6);
      wait (wr_seen >= base + 2);
      wr(R_CTRL, mk_ctrl(0, 3, 1, 1, 0, 0, 1, 2, 0, 0));
      idle(10);
      base = wr_seen;
      idle(30);
      check("R9", "writes frozen while paused", 32'(wr_seen), 32'(base));
      check("R9", "request low while paused", {31'b0, mem_req}, 32'd0);
      rd(R_STAT, v);  check("R9", "buffer not done while paused", v, 32'd0);
      wr(R_CTRL, mk_ctrl(0, 3, 1, 1, 0, 0, 0, 2, 0, 0));
      wait_flags(32'h1, "R9");

      // R12 channel reset during a wait gap
      wr(R_CTRL, mk_ctrl(0, 20, 1, 1, 0, 0, 0, 2, 0, 0) | 32'h180);
      wr(R_ASRC, 32'hB00); wr(R_ADST, 32'hC00);
      expect_elems(32'hB00, 32'hC00, 1, 4, 4, 2'd2);
      base = wr_seen;
      wr(R_ACNT, 32'd5);
      wait (wr_seen >= base + 1);
      wr(R_CTRL, mk_ctrl(0, 20, 1, 1, 0, 0, 0, 2, 0, 0) | 32'h20);
      idle(40);
      check("R12", "no request after reset", {31'b0, mem_req}, 32'd0);
      rd(R_ACNT, v);  check("R12", "A count cleared", v, 32'd0);
      rd(R_ASRC, v);  check("R12", "A source cleared", v, 32'd0);
      rd(R_STAT, v);  check("R12", "flags cleared", v, 32'd0);

      // R13 control fields and strobe masking
      c = mk_ctrl(10, 0, 0, 0, 1, 0, 0, 0, 1, 0);
      wr(R_CTRL, c | 32'h180);
      check("R13", "periph_sel", {28'b0, periph_sel}, 32'hA);
      check("R13", "chan_dir", {31'b0, chan_dir}, 32'd1);
      check("R13", "chan_hi_pri", {31'b0, chan_hi_pri}, 32'd1);
      rd(R_CTRL, v);  check("R13", "control readback", v, c);

      check("R3", "scoreboard drained", 32'(exp_q.size()), 32'd0);
      summary();
   end

endmodule